// File: doc/BRIEF.md
# Validated Receive Message Buffer

This block sits between a serial-bus word decoder and a shared message RAM. For each receive message it takes the verified command word and then the decoded data words. It holds the data words in a private staging FIFO and does not write them to the RAM while the message is still arriving. The RAM therefore stays free for the local processor during the message. It also never holds data from a message that later turns out to be bad.

When the command is accepted, a one-cycle command strobe presents the command word. In that same cycle an illegalize input can reject the message. If a data word is flagged bad, the word count comes out wrong, or a new command cuts the message short, the staged words are thrown away. A message that completes cleanly raises an active-low completion strobe of parameterised width, with the command word on the output bus. A burst then copies the staged words into the RAM at one word per clock, starting at an address set by the command's subaddress field. A single-cycle done pulse closes the burst.

Top module: `rxb_msg_buffer`

## Requirements
- R1: After reset, cmd_stb_o is 0, msg_done_no is 1, ram_we_o is 0 and dma_done_o is 0.
- R2: A cmd_valid_i sampled while the block is idle raises cmd_stb_o for exactly one cycle, starting in the next cycle, and cmd_bus_o shows that command word while cmd_stb_o is high.
- R3: If illegal_i is high in the cycle cmd_stb_o is high, the message is dropped: its data words are ignored, msg_done_no stays 1 and no RAM write occurs.
- R4: The expected data-word count is command bits [4:0], where 0 stands for 32 words.
- R5: Data words are held in the staging FIFO, and ram_we_o is never high while msg_done_no is low or before the message completes.
- R6: A data word that arrives with data_err_i high flushes the staged words: no completion strobe and no RAM write follow for that message.
- R7: A message whose end marker arrives after fewer words than expected, or that receives a word beyond the expected count, is flushed with no completion strobe and no RAM write.
- R8: For a valid message, msg_done_no goes low in the cycle after msg_end_i is sampled, stays low for exactly STB_CYC cycles, and cmd_bus_o shows the message's command word throughout.
- R9: The burst starts in the cycle after msg_done_no returns high. It writes one word per cycle for N consecutive cycles, where N is the expected count, to address subaddress*32 + i, with the subaddress taken from command bits [9:5]. Word i is the i-th data word received.
- R10: dma_done_o pulses for one cycle, in the cycle after the last burst write.
- R11: A cmd_valid_i sampled while data words are being received aborts that message (its words are flushed and never written) and starts the new message.
- R12: A cmd_valid_i sampled during the completion strobe or the burst is ignored: no cmd_stb_o, and cmd_bus_o keeps the current command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Verified command word present |
| cmd_word_i | input | 16 | Command word |
| illegal_i | input | 1 | Reject the message; sampled while cmd_stb_o is high |
| data_valid_i | input | 1 | Decoded data word present |
| data_word_i | input | 16 | Data word |
| data_err_i | input | 1 | Data word failed its checks |
| msg_end_i | input | 1 | Message ended on the bus |
| cmd_stb_o | output | 1 | Command accepted strobe |
| cmd_bus_o | output | 16 | Current command word |
| msg_done_no | output | 1 | Validated message complete, active low |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 10 | RAM write address |
| ram_wdata_o | output | 16 | RAM write data |
| dma_done_o | output | 1 | Burst finished pulse |

## Verification
Faults in the word counter or the staging pointers appear at the RAM port within the same message's burst. They show up as a wrong burst length, words shifted or repeated, or a missing completion strobe on a message that should pass. A sequencer that forgets to flush shows up on the next message: stale words are written, or a bad message is committed to the RAM. Each message is therefore checked for strobe count, strobe width, write count, write addresses and data, and done pulse timing before the next message starts. Strobe and burst placement are checked to the exact cycle.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_RECV,
    S_STB,
    S_DMA
  } seq_state_e;
endpackage

// File: rtl/rxb_stage_fifo.sv
module rxb_stage_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  a_r5_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !flush_i |-> cnt_q < CW'(DEPTH));
  a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/rxb_seq.sv
module rxb_seq
  import rxb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int STB_CYC   = 4,
  parameter int WC_LSB    = 0,
  parameter int SA_LSB    = 5,
  parameter int SA_W      = 5,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int STB_W    = $clog2(STB_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              illegal_i,
  input  logic              data_valid_i,
  input  logic              data_err_i,
  input  logic              msg_end_i,
  input  logic              dma_done_i,
  output logic              cmd_stb_o,
  output logic [DATA_W-1:0] cmd_bus_o,
  output logic              msg_done_no,
  output logic              push_o,
  output logic              flush_o,
  output logic              dma_start_o,
  output logic [CNT_W-1:0]  exp_len_o,
  output logic [SA_W-1:0]   base_o
);
  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STB_W-1:0]  stb_q, stb_d;
  logic [IDX_W-1:0]  wc_field;
  logic [CNT_W-1:0]  exp_len;
  logic              bad_word;

  // word count field of zero encodes a full-size message
  assign wc_field = cmd_q[WC_LSB +: IDX_W];
  assign exp_len  = (wc_field == '0) ? CNT_W'(MAX_WORDS) : CNT_W'(wc_field);
  assign bad_word = data_valid_i && (data_err_i || cnt_q == exp_len);

  always_comb begin
    st_d        = st_q;
    cmd_d       = cmd_q;
    cnt_d       = cnt_q;
    stb_d       = stb_q;
    push_o      = 1'b0;
    flush_o     = 1'b0;
    dma_start_o = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_valid_i) begin
          cmd_d = cmd_word_i;
          cnt_d = '0;
          st_d  = S_CMD;
        end
      end
      S_CMD: st_d = illegal_i ? S_IDLE : S_RECV;
      S_RECV: begin
        if (cmd_valid_i) begin
          flush_o = 1'b1;
          cmd_d   = cmd_word_i;
          cnt_d   = '0;
          st_d    = S_CMD;
        end else if (bad_word) begin
          flush_o = 1'b1;
          st_d    = S_IDLE;
        end else begin
          push_o = data_valid_i;
          cnt_d  = cnt_q + CNT_W'(data_valid_i);
          if (msg_end_i) begin
            if (cnt_d == exp_len) begin
              stb_d = '0;
              st_d  = S_STB;
            end else begin
              flush_o = 1'b1;
              st_d    = S_IDLE;
            end
          end
        end
      end
      S_STB: begin
        if (stb_q == STB_W'(STB_CYC - 1)) begin
          dma_start_o = 1'b1;
          st_d        = S_DMA;
        end else begin
          stb_d = stb_q + 1'b1;
        end
      end
      S_DMA: if (dma_done_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cmd_q <= '0;
      cnt_q <= '0;
      stb_q <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign cmd_stb_o   = (st_q == S_CMD);
  assign msg_done_no = (st_q != S_STB);
  assign cmd_bus_o   = cmd_q;
  assign exp_len_o   = exp_len;
  assign base_o      = cmd_q[SA_LSB +: SA_W];

  a_r2_cmd_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);
  a_r3_illegal_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o && illegal_i |=> st_q == S_IDLE);
  a_r7_no_excess_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> cnt_q < exp_len);
  a_r12_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_STB || st_q == S_DMA) |=> $stable(cmd_bus_o));
endmodule

// File: rtl/rxb_dma.sv
module rxb_dma #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int SA_W      = 5,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int ADDR_W   = SA_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [SA_W-1:0]   base_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              pop_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              done_o
);
  logic             active_q, done_q;
  logic [CNT_W-1:0] idx_q;
  logic             last;

  assign last = active_q && (idx_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      done_q <= last;
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (last) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign pop_o       = active_q;
  assign ram_we_o    = active_q;
  assign ram_addr_o  = {base_i, idx_q[IDX_W-1:0]};
  assign ram_wdata_o = rdata_i;
  assign done_o      = done_q;

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_start_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> len_i != '0 && !active_q);
endmodule

// File: rtl/rxb_msg_buffer.sv
module rxb_msg_buffer #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int STB_CYC   = 4,
  parameter int WC_LSB    = 0,
  parameter int SA_LSB    = 5,
  parameter int SA_W      = 5,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int ADDR_W   = SA_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              illegal_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_word_i,
  input  logic              data_err_i,
  input  logic              msg_end_i,
  output logic              cmd_stb_o,
  output logic [DATA_W-1:0] cmd_bus_o,
  output logic              msg_done_no,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              dma_done_o
);
  logic              push, flush, pop, dma_start;
  logic [CNT_W-1:0]  exp_len;
  logic [SA_W-1:0]   base;
  logic [DATA_W-1:0] fifo_rdata;
  logic [CNT_W-1:0]  fifo_count;

  rxb_seq #(
    .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .STB_CYC(STB_CYC),
    .WC_LSB(WC_LSB), .SA_LSB(SA_LSB), .SA_W(SA_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_word_i, .illegal_i,
    .data_valid_i, .data_err_i, .msg_end_i,
    .dma_done_i (dma_done_o),
    .cmd_stb_o, .cmd_bus_o, .msg_done_no,
    .push_o     (push),
    .flush_o    (flush),
    .dma_start_o(dma_start),
    .exp_len_o  (exp_len),
    .base_o     (base)
  );

  rxb_stage_fifo #(.W(DATA_W), .DEPTH(MAX_WORDS)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush),
    .push_i (push),
    .wdata_i(data_word_i),
    .pop_i  (pop),
    .rdata_o(fifo_rdata),
    .count_o(fifo_count)
  );

  rxb_dma #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .SA_W(SA_W)) u_dma (
    .clk_i, .rst_ni,
    .start_i    (dma_start),
    .len_i      (exp_len),
    .base_i     (base),
    .rdata_i    (fifo_rdata),
    .pop_o      (pop),
    .ram_we_o,
    .ram_addr_o,
    .ram_wdata_o,
    .done_o     (dma_done_o)
  );

  a_r5_no_write_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_done_no |-> !ram_we_o);
  a_r9_burst_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_done_no) |-> ram_we_o);
  a_r9_full_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start |-> fifo_count == exp_len);
  a_r10_done_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_o) |-> dma_done_o);
endmodule

// File: tb/tb_rxb_msg_buffer.sv
module tb_rxb_msg_buffer;
  localparam int STB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, illegal = 0, data_valid = 0, data_err = 0, msg_end = 0;
  logic [15:0] cmd_word = '0, data_word = '0;
  logic        cmd_stb, msg_done_n, ram_we, dma_done;
  logic [15:0] cmd_bus, ram_wdata;
  logic [9:0]  ram_addr;

  always #2.5 clk = ~clk;

  rxb_msg_buffer #(.STB_CYC(STB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word), .illegal_i(illegal),
    .data_valid_i(data_valid), .data_word_i(data_word), .data_err_i(data_err),
    .msg_end_i(msg_end),
    .cmd_stb_o(cmd_stb), .cmd_bus_o(cmd_bus), .msg_done_no(msg_done_n),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .dma_done_o(dma_done)
  );

  int checks = 0, failures = 0;

  // monitor accumulators
  int n_stb, n_low, bad_bus, overlap, n_wr, n_dd, bad_dd, gap, first_wr_low;
  logic [15:0] stb_bus, cur_cmd;
  logic [9:0]  wr_addr [64];
  logic [15:0] wr_data [64];
  logic        prev_we;
  logic        seen_we;

  // bench record of the message being sent
  logic [15:0] sent [64];
  int          n_sent;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_stb) begin n_stb++; stb_bus = cmd_bus; end
      if (!msg_done_n) begin
        n_low++;
        if (cmd_bus !== cur_cmd) bad_bus++;
        if (ram_we) overlap++;
      end
      if (ram_we) begin
        if (n_wr == 0) first_wr_low = n_low;
        if (seen_we && !prev_we) gap++;
        if (n_wr < 64) begin wr_addr[n_wr] = ram_addr; wr_data[n_wr] = ram_wdata; end
        n_wr++;
        seen_we = 1'b1;
      end
      if (dma_done) begin
        n_dd++;
        if (!prev_we || ram_we) bad_dd++;
      end
      prev_we = ram_we;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input logic [15:0] c);
    return (c[4:0] == 5'd0) ? 32 : int'(c[4:0]);
  endfunction

  function automatic logic [15:0] mk_cmd(input int sa, input int wc);
    logic [5:0] top = 6'($urandom);
    return {top, sa[4:0], wc[4:0]};
  endfunction

  task automatic clear_mon();
    n_stb = 0; n_low = 0; bad_bus = 0; overlap = 0; n_wr = 0; n_dd = 0;
    bad_dd = 0; gap = 0; first_wr_low = -1; prev_we = 0; seen_we = 0; stb_bus = '0;
  endtask

  task automatic drive_cmd(input logic [15:0] c, input bit ill);
    cmd_valid = 1; cmd_word = c;
    @(negedge clk);
    cmd_valid = 0; illegal = ill;
    cur_cmd = c; n_sent = 0;
    @(negedge clk);
    illegal = 0;
  endtask

  task automatic drive_word(input logic [15:0] w, input bit err);
    data_valid = 1; data_word = w; data_err = err;
    if (n_sent < 64) sent[n_sent] = w;
    n_sent++;
    @(negedge clk);
    data_valid = 0; data_err = 0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic drive_end(output bit low_next);
    msg_end = 1;
    @(negedge clk);
    msg_end = 0;
    low_next = !msg_done_n;
  endtask

  // Checks the outcome of one message; valid says whether it must commit.
  task automatic judge(input bit valid, input int n, input string tag);
    int bad_w = 0;
    int sa = int'(cur_cmd[9:5]);
    chk(n_low == (valid ? STB : 0), valid ? "R8 strobe width" : tag, n_low, valid ? STB : 0);
    chk(bad_bus == 0, "R8 cmd_bus during strobe", bad_bus, 0);
    chk(n_wr == (valid ? n : 0), valid ? "R9 write count" : tag, n_wr, valid ? n : 0);
    if (valid && n_wr == n) begin
      for (int i = 0; i < n; i++)
        if (wr_addr[i] !== 10'(sa * 32 + i) || wr_data[i] !== sent[i]) bad_w++;
      chk(bad_w == 0, "R9 write address/data", bad_w, 0);
      chk(gap == 0, "R9 consecutive writes", gap, 0);
      chk(first_wr_low == STB, "R5 burst after strobe", first_wr_low, STB);
    end
    chk(overlap == 0, "R5 no write during strobe", overlap, 0);
    chk(n_dd == (valid ? 1 : 0) && bad_dd == 0, "R10 done pulse", n_dd * 10 + bad_dd,
        valid ? 10 : 0);
  endtask

  // Full message: err_at < 0 means no error word; n words sent.
  task automatic send_msg(input logic [15:0] c, input int n, input int err_at,
                          input bit ill, input string tag);
    bit low_next;
    bit valid = !ill && err_at < 0 && n == exp_n(c);
    clear_mon();
    drive_cmd(c, ill);
    chk(n_stb == 1 && stb_bus == c, "R2 command strobe", n_stb, 1);
    for (int i = 0; i < n; i++) drive_word(16'($urandom), i == err_at);
    drive_end(low_next);
    if (valid) chk(low_next, "R8 strobe starts after end", int'(low_next), 1);
    repeat (STB + 40) @(negedge clk);
    judge(valid, exp_n(c), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit low_next;
    logic [15:0] ca, cb;
    void'($urandom(32'hC0FFEE));
    clear_mon();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_stb == 0 && msg_done_n == 1 && ram_we == 0 && dma_done == 0, "R1 reset outputs",
        {cmd_stb, msg_done_n, ram_we, dma_done}, 4'b0100);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_stb == 0 && msg_done_n == 1 && ram_we == 0, "R1 after release",
        {cmd_stb, msg_done_n, ram_we}, 3'b010);

    // R4 word-count encodings
    send_msg(mk_cmd(3, 0), 32, -1, 0, "R4");
    send_msg(mk_cmd(31, 1), 1, -1, 0, "R4");
    send_msg(mk_cmd(0, 31), 31, -1, 0, "R4");
    // R3 illegalized message
    send_msg(mk_cmd(7, 4), 4, -1, 1, "R3 illegal dropped");
    // R6 error word at first and last position
    send_msg(mk_cmd(9, 5), 5, 0, 0, "R6 error flush");
    send_msg(mk_cmd(9, 5), 5, 4, 0, "R6 error flush");
    // R7 short and long messages
    send_msg(mk_cmd(12, 6), 5, -1, 0, "R7 short flush");
    send_msg(mk_cmd(12, 6), 7, -1, 0, "R7 long flush");
    // a clean message after flushes must carry no stale data
    send_msg(mk_cmd(12, 6), 6, -1, 0, "R6 clean after flush");

    // R11 new command aborts a message in progress
    ca = mk_cmd(20, 8); cb = mk_cmd(21, 3);
    clear_mon();
    drive_cmd(ca, 0);
    for (int i = 0; i < 4; i++) drive_word(16'($urandom), 0);
    drive_cmd(cb, 0);
    for (int i = 0; i < 3; i++) drive_word(16'($urandom), 0);
    drive_end(low_next);
    repeat (STB + 40) @(negedge clk);
    chk(n_stb == 2, "R11 both commands strobed", n_stb, 2);
    judge(1, 3, "R11 abort");

    // R12 command during strobe ignored
    ca = mk_cmd(25, 2);
    clear_mon();
    drive_cmd(ca, 0);
    drive_word(16'($urandom), 0);
    drive_word(16'($urandom), 0);
    drive_end(low_next);
    cmd_valid = 1; cmd_word = ~ca;
    @(negedge clk);
    cmd_valid = 0;
    repeat (STB + 40) @(negedge clk);
    chk(n_stb == 1, "R12 command ignored in strobe", n_stb, 1);
    chk(cmd_bus == ca, "R12 cmd_bus kept", int'(cmd_bus), int'(ca));
    judge(1, 2, "R12");

    // random mix
    for (int k = 0; k < 24; k++) begin
      int sa = $urandom % 32;
      int wc = $urandom % 32;
      logic [15:0] c = mk_cmd(sa, wc);
      int n = exp_n(c);
      int mode = $urandom % 6;
      case (mode)
        3: send_msg(c, n, $urandom % n, 0, "R6 random error");
        4: send_msg(c, (n > 1) ? n - 1 : n + 1, -1, 0, "R7 random count");
        5: send_msg(c, n, -1, ($urandom % 2) == 1, "R3 random illegal");
        default: send_msg(c, n, -1, 0, "R9 random");
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule